// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline. It decides, for each of the two ALU operands, whether the value read from the register file is still current. If it is not, the block substitutes the newer value that is still travelling down the pipeline. A result that is one instruction old is taken from the execute/memory boundary register. A result that is two instructions old is taken from the memory/write-back boundary register. A dependent instruction can therefore issue right behind its producer without waiting for write-back.

For each operand, the block emits a 2-bit source select and the selected operand value. The value from the write-back boundary is whatever that stage will write: either the loaded memory word or the ALU result, chosen by that stage's memory-to-register flag. Register 0 is hard-wired to zero, so it is never a forwarding target. The block is purely combinational. It has no state, so no states or transitions are named. Stall generation and forwarding of store data into the memory stage belong to neighbouring blocks.

Top module: `operand_forward`

## Requirements
- R1: When the execute/memory stage has its write flag set, a non-zero destination, and that destination equals an operand's source register, that operand's select is 2'b10.
- R2: When R1 does not apply to an operand, and the memory/write-back stage has its write flag set, a non-zero destination, and that destination equals the operand's source register, the select is 2'b01.
- R3: When both stages write the same non-zero register that an operand reads, the execute/memory stage (the younger producer) wins and the select is 2'b10.
- R4: A source register of 0 always gives select 2'b00 and an operand equal to the register-file value, even when a stage writes register 0.
- R5: A stage whose write flag is clear never causes forwarding, even when its destination matches.
- R6: Select 2'b00 passes the register-file read value for that operand unchanged.
- R7: Select 2'b10 passes the execute/memory ALU result.
- R8: Select 2'b01 passes the write-back value: the load data when the memory-to-register flag is 1, otherwise the write-back stage's ALU result.
- R9: The select code 2'b11 is never produced. If the operand mux ever receives it, the mux treats it as 2'b00.
- R10: The two operands are resolved independently. In the same cycle, one operand may come from one stage and the other operand from the other stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | Source register number of operand A in the execute stage |
| ex_src_b | input | REG_W | Source register number of operand B in the execute stage |
| rf_data_a | input | DATA_W | Register-file read value for operand A |
| rf_data_b | input | DATA_W | Register-file read value for operand B |
| exm_wr_en | input | 1 | Execute/memory stage will write a register |
| exm_dst | input | REG_W | Execute/memory stage destination register |
| exm_alu_res | input | DATA_W | Execute/memory stage ALU result |
| mwb_wr_en | input | 1 | Memory/write-back stage will write a register |
| mwb_dst | input | REG_W | Memory/write-back stage destination register |
| mwb_mem_to_reg | input | 1 | 1: write-back value is load data; 0: ALU result |
| mwb_load_data | input | DATA_W | Load data in the memory/write-back stage |
| mwb_alu_res | input | DATA_W | ALU result in the memory/write-back stage |
| sel_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 execute/memory |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
The assertions assume that a load sitting in the execute/memory stage is never consumed by the instruction right behind it. Forwarding would hand over the load's address rather than its data, so a stall unit outside this block must prevent that case. The stimulus generator keeps to this rule: whenever the instruction in the execute/memory stage is a load, it redirects any source register that matches the load's destination to register 0. All other inputs are free, including a write to register 0 and a destination that matches while the write flag is clear. The reference model tracks the architectural register state in program order, so every forwarded operand is compared against the value a non-pipelined machine would read.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source select codes; the numeric values are visible on the ports.
    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_MWB   = 2'b01,
        SRC_EXM   = 2'b10,
        SRC_RSVD  = 2'b11
    } src_sel_e;

    localparam int NUM_OPND = 2;

endpackage

// File: rtl/fwd_src_select.sv
// Chooses the source of one execute-stage operand from the in-flight producers.
module fwd_src_select
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic             exm_wr_en,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             mwb_wr_en,
    input  logic [REG_W-1:0] mwb_dst,
    output src_sel_e         sel
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic src_live;
    logic exm_hit;
    logic mwb_hit;

    // A read of the zero register never needs a newer value.
    assign src_live = (src_reg != ZERO_REG);

    assign exm_hit = src_live && exm_wr_en && (exm_dst == src_reg);
    assign mwb_hit = src_live && mwb_wr_en && (mwb_dst == src_reg);

    // The younger producer has priority over the older one.
    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10,
            2'b11:   sel = SRC_EXM;
            2'b01:   sel = SRC_MWB;
            default: sel = SRC_RF;
        endcase
    end

endmodule

// File: rtl/fwd_wb_value.sv
// Forms the value that the write-back stage is about to commit.
module fwd_wb_value #(
    parameter int DATA_W = 32
) (
    input  logic              mem_to_reg,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] wb_value
);

    always_comb begin
        if (mem_to_reg) begin
            wb_value = load_data;
        end else begin
            wb_value = alu_res;
        end
    end

endmodule

// File: rtl/fwd_operand_mux.sv
// Three-way operand mux; the reserved code falls back to the register file.
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_value,
    input  logic [DATA_W-1:0] mwb_value,
    input  logic [DATA_W-1:0] exm_value,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        unique case (sel)
            SRC_EXM:  opnd = exm_value;
            SRC_MWB:  opnd = mwb_value;
            SRC_RF:   opnd = rf_value;
            SRC_RSVD: opnd = rf_value;
            default:  opnd = rf_value;
        endcase
    end

endmodule

// File: rtl/operand_forward.sv
// Execute-stage operand forwarding: per-operand source select and operand mux.
module operand_forward
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  ex_src_a,
    input  logic [REG_W-1:0]  ex_src_b,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic              exm_wr_en,
    input  logic [REG_W-1:0]  exm_dst,
    input  logic [DATA_W-1:0] exm_alu_res,
    input  logic              mwb_wr_en,
    input  logic [REG_W-1:0]  mwb_dst,
    input  logic              mwb_mem_to_reg,
    input  logic [DATA_W-1:0] mwb_load_data,
    input  logic [DATA_W-1:0] mwb_alu_res,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    logic [DATA_W-1:0] wb_value;

    logic [NUM_OPND-1:0][REG_W-1:0]  src_vec;
    logic [NUM_OPND-1:0][DATA_W-1:0] rf_vec;
    logic [NUM_OPND-1:0][DATA_W-1:0] opnd_vec;
    src_sel_e                        sel_vec [NUM_OPND];

    assign src_vec[0] = ex_src_a;
    assign src_vec[1] = ex_src_b;
    assign rf_vec[0]  = rf_data_a;
    assign rf_vec[1]  = rf_data_b;

    // One shared write-back value feeds both operand muxes.
    fwd_wb_value #(
        .DATA_W (DATA_W)
    ) u_wb_value (
        .mem_to_reg (mwb_mem_to_reg),
        .load_data  (mwb_load_data),
        .alu_res    (mwb_alu_res),
        .wb_value   (wb_value)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_src_select #(
            .REG_W (REG_W)
        ) u_select (
            .src_reg   (src_vec[g]),
            .exm_wr_en (exm_wr_en),
            .exm_dst   (exm_dst),
            .mwb_wr_en (mwb_wr_en),
            .mwb_dst   (mwb_dst),
            .sel       (sel_vec[g])
        );

        fwd_operand_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel       (sel_vec[g]),
            .rf_value  (rf_vec[g]),
            .mwb_value (wb_value),
            .exm_value (exm_alu_res),
            .opnd      (opnd_vec[g])
        );
    end

    assign sel_a  = sel_vec[0];
    assign sel_b  = sel_vec[1];
    assign opnd_a = opnd_vec[0];
    assign opnd_b = opnd_vec[1];

endmodule

// File: rtl/operand_forward_chk.sv
// Port-level checker for operand_forward, attached with bind below.
module operand_forward_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  ex_src_a,
    input logic [REG_W-1:0]  ex_src_b,
    input logic [DATA_W-1:0] rf_data_a,
    input logic [DATA_W-1:0] rf_data_b,
    input logic              exm_wr_en,
    input logic [REG_W-1:0]  exm_dst,
    input logic [DATA_W-1:0] exm_alu_res,
    input logic              mwb_wr_en,
    input logic [REG_W-1:0]  mwb_dst,
    input logic              mwb_mem_to_reg,
    input logic [DATA_W-1:0] mwb_load_data,
    input logic [DATA_W-1:0] mwb_alu_res,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    logic [DATA_W-1:0] wb_exp;

    always_comb begin
        wb_exp = mwb_mem_to_reg ? mwb_load_data : mwb_alu_res;

        AST_SEL_A_LEGAL: assert (sel_a != 2'b11) else $error("sel_a reserved");  // R9
        AST_SEL_B_LEGAL: assert (sel_b != 2'b11) else $error("sel_b reserved");  // R9

        if (exm_wr_en && exm_dst != '0 && exm_dst == ex_src_a) begin
            AST_EXM_WINS_A: assert (sel_a == 2'b10) else $error("A not from exm");  // R3
        end
        if (exm_wr_en && exm_dst != '0 && exm_dst == ex_src_b) begin
            AST_EXM_WINS_B: assert (sel_b == 2'b10) else $error("B not from exm");  // R1
        end
        if (ex_src_a == '0) begin
            AST_ZERO_SRC_A: assert (sel_a == 2'b00 && opnd_a == rf_data_a) else $error("A zero src");  // R4
        end
        if (ex_src_b == '0) begin
            AST_ZERO_SRC_B: assert (sel_b == 2'b00 && opnd_b == rf_data_b) else $error("B zero src");  // R4
        end
        if (!exm_wr_en && !mwb_wr_en) begin
            AST_NO_WRITER: assert (sel_a == 2'b00 && sel_b == 2'b00) else $error("forward w/o writer");  // R5
        end
        if (sel_a == 2'b00) begin
            AST_OPND_RF_A: assert (opnd_a == rf_data_a) else $error("A rf path");  // R6
        end
        if (sel_b == 2'b10) begin
            AST_OPND_EXM_B: assert (opnd_b == exm_alu_res) else $error("B exm path");  // R7
        end
        if (sel_a == 2'b01) begin
            AST_OPND_MWB_A: assert (opnd_a == wb_exp) else $error("A wb path");  // R8
        end
        if (sel_b == 2'b01) begin
            AST_OPND_MWB_B: assert (opnd_b == wb_exp) else $error("B wb path");  // R8
        end
    end

endmodule

bind operand_forward operand_forward_chk #(
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/operand_forward_tb.sv
module operand_forward_tb;

    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NREG   = 1 << REG_W;

    typedef struct {
        int          dst;
        bit          wr;
        bit          m2r;
        logic [31:0] alu;
        logic [31:0] ld;
    } instr_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [REG_W-1:0]  ex_src_a, ex_src_b, exm_dst, mwb_dst;
    logic [DATA_W-1:0] rf_data_a, rf_data_b, exm_alu_res, mwb_load_data, mwb_alu_res;
    logic              exm_wr_en, mwb_wr_en, mwb_mem_to_reg;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    operand_forward #(.REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
        .ex_src_a       (ex_src_a),
        .ex_src_b       (ex_src_b),
        .rf_data_a      (rf_data_a),
        .rf_data_b      (rf_data_b),
        .exm_wr_en      (exm_wr_en),
        .exm_dst        (exm_dst),
        .exm_alu_res    (exm_alu_res),
        .mwb_wr_en      (mwb_wr_en),
        .mwb_dst        (mwb_dst),
        .mwb_mem_to_reg (mwb_mem_to_reg),
        .mwb_load_data  (mwb_load_data),
        .mwb_alu_res    (mwb_alu_res),
        .sel_a          (sel_a),
        .sel_b          (sel_b),
        .opnd_a         (opnd_a),
        .opnd_b         (opnd_b)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] arch [NREG];   // program-order register state
    logic [31:0] rfm  [NREG];   // register file as the pipeline sees it
    instr_t      in_exm, in_mwb;

    function automatic logic [31:0] wb_of(instr_t i);
        return i.m2r ? i.ld : i.alu;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected select from the rules: youngest writing producer, never reg 0.
    function automatic int exp_sel(int src);
        if (src == 0) return 0;
        if (in_exm.wr && in_exm.dst == src) return 2;
        if (in_mwb.wr && in_mwb.dst == src) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int s);
        return (s == 2) ? "R1" : (s == 1) ? "R2" : "R5";
    endfunction

    function automatic string opnd_tag(int s);
        return (s == 2) ? "R7" : (s == 1) ? "R8" : "R6";
    endfunction

    task automatic reset_model();
        for (int r = 0; r < NREG; r++) begin
            arch[r] = '0;
            rfm[r]  = '0;
        end
        in_exm = '{dst: 0, wr: 0, m2r: 0, alu: 0, ld: 0};
        in_mwb = in_exm;
    endtask

    // Issue one instruction into execute; compare every output at the negedge.
    task automatic issue(input int dst, input bit wr, input bit m2r, input int sa_in, input int sb_in);
        instr_t nw;
        int sa, sb, ea, eb;
        sa = sa_in;
        sb = sb_in;
        // Load-use is stalled upstream: never read a load result one slot behind.
        if (in_exm.wr && in_exm.m2r && in_exm.dst == sa) sa = 0;
        if (in_exm.wr && in_exm.m2r && in_exm.dst == sb) sb = 0;
        nw.dst = dst; nw.wr = wr; nw.m2r = m2r;
        nw.alu = $urandom; nw.ld = $urandom;

        @(posedge clk);
        #1;
        ex_src_a       = REG_W'(sa);
        ex_src_b       = REG_W'(sb);
        rf_data_a      = rfm[sa];
        rf_data_b      = rfm[sb];
        exm_wr_en      = in_exm.wr;
        exm_dst        = REG_W'(in_exm.dst);
        exm_alu_res    = in_exm.alu;
        mwb_wr_en      = in_mwb.wr;
        mwb_dst        = REG_W'(in_mwb.dst);
        mwb_mem_to_reg = in_mwb.m2r;
        mwb_load_data  = in_mwb.ld;
        mwb_alu_res    = in_mwb.alu;

        @(negedge clk);
        ea = exp_sel(sa);
        eb = exp_sel(sb);
        chk(sel_tag(ea),  "sel_a",  32'(sel_a),  32'(ea));
        chk(sel_tag(eb),  "sel_b",  32'(sel_b),  32'(eb));
        chk(opnd_tag(ea), "opnd_a", opnd_a, arch[sa]);
        chk(opnd_tag(eb), "opnd_b", opnd_b, arch[sb]);
        chk("R9", "sel_a legal", 32'(sel_a == 2'b11), 32'd0);

        if (in_mwb.wr && in_mwb.dst != 0) rfm[in_mwb.dst] = wb_of(in_mwb);
        if (nw.wr && nw.dst != 0) arch[nw.dst] = wb_of(nw);
        in_mwb = in_exm;
        in_exm = nw;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        reset_model();
        ex_src_a = '0; ex_src_b = '0; rf_data_a = '0; rf_data_b = '0;
        exm_wr_en = 0; exm_dst = '0; exm_alu_res = '0;
        mwb_wr_en = 0; mwb_dst = '0; mwb_mem_to_reg = 0;
        mwb_load_data = '0; mwb_alu_res = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: nothing in flight.
        @(negedge clk);
        chk("R6", "idle sel_a", 32'(sel_a), 32'd0);
        chk("R6", "idle sel_b", 32'(sel_b), 32'd0);
        chk("R6", "idle opnd_a", opnd_a, 32'd0);

        // Producer then four readers back to back (R1, R2, R6).
        issue(2, 1, 0, 1, 3);
        issue(12, 1, 0, 2, 5);
        chk("R1", "dep+1 sel_a", 32'(sel_a), 32'd2);
        issue(13, 1, 0, 6, 2);
        chk("R2", "dep+2 sel_b", 32'(sel_b), 32'd1);
        issue(14, 1, 0, 2, 2);
        chk("R6", "dep+3 sel_a", 32'(sel_a), 32'd0);
        issue(15, 0, 0, 15, 2);

        // Both stages write the same register (R3).
        issue(3, 1, 1, 0, 0);
        issue(3, 1, 0, 0, 0);
        issue(0, 0, 0, 3, 0);
        chk("R3", "both match sel_a", 32'(sel_a), 32'd2);
        chk("R3", "both match opnd_a", opnd_a, exm_alu_res);

        // Load result through the write-back path (R8).
        issue(4, 1, 1, 0, 0);
        issue(0, 0, 0, 0, 0);
        issue(0, 0, 0, 0, 4);
        chk("R8", "load fwd sel_b", 32'(sel_b), 32'd1);
        chk("R8", "load fwd opnd_b", opnd_b, mwb_load_data);

        // Write to register 0 (R4).
        issue(0, 1, 0, 0, 0);
        issue(0, 1, 0, 0, 0);
        chk("R4", "r0 sel_a", 32'(sel_a), 32'd0);
        chk("R4", "r0 opnd_a", opnd_a, 32'd0);

        // Matching destination with write flag clear (R5).
        issue(5, 0, 0, 0, 0);
        issue(6, 0, 0, 5, 5);
        chk("R5", "no wr sel_a", 32'(sel_a), 32'd0);
        chk("R5", "no wr opnd_a", opnd_a, rf_data_a);

        // Different sources per operand in one cycle (R10).
        issue(6, 1, 0, 0, 0);
        issue(7, 1, 0, 0, 0);
        issue(0, 0, 0, 7, 6);
        chk("R10", "split sel_a", 32'(sel_a), 32'd2);
        chk("R10", "split sel_b", 32'(sel_b), 32'd1);

        // Random dependent stream over a small register window.
        for (int k = 0; k < 2000; k++) begin
            issue($urandom_range(7), ($urandom_range(9) < 8), ($urandom_range(9) < 3),
                  $urandom_range(7), $urandom_range(7));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule